// File: doc/BRIEF.md
# Bus Cycle Termination Arbiter

This block sits in a synchronous bus master and decides how each bus cycle ends. Once a cycle is running it samples three active-low status lines from the addressed slave on every rising clock edge: transfer acknowledge, bus error and halt. It reports the outcome as a one-clock done strobe with a two-bit termination code. The outcome is one of normal completion, bus-error termination or retry request.

Bus error always outranks acknowledge. When acknowledge arrives alone, the arbiter holds the result for one more clock. A bus error raised in that extra window turns the cycle that looked finished into a bus-error cycle. Whenever the result is not a normal completion, a flag marks the captured read data as invalid.

A bus-error termination also produces an exception request. The request is either raised together with the done strobe or held pending until the core releases it, as chosen by a deferral input. A new cycle is accepted only when all three status lines read negated, so a bus error that stays asserted cannot leak into the next cycle.

Top module: `bus_term_arbiter`

## Requirements
- R1: After reset the unit is idle: `cyc_busy`, `cyc_done`, `data_invalid`, `exc_req` and `exc_pending` are 0 and `term_code` is 2'b00.
- R2: A cycle starts only at a rising edge where `cyc_start` is 1 and `ack_n`, `berr_n` and `halt_n` are all 1; `cyc_busy` is 1 from that edge on. If any status line is low at that edge, the start is ignored and `cyc_busy` stays 0.
- R3: During a cycle, an edge with bus error low while acknowledge and halt are high ends the cycle as a bus error: `cyc_done`=1 with `term_code`=2'b01 after that edge.
- R4: During a cycle, an edge with acknowledge low and bus error and halt high does not end the cycle. If the next edge sees bus error high (and halt high, or halt low without bus error), the cycle ends normally with `term_code`=2'b00.
- R5: If bus error is low at the edge after the acknowledge, and halt is high, the cycle ends with `term_code`=2'b01 instead of a normal completion.
- R6: Bus error and halt low together at a deciding edge, in the active phase or in the late window, end the cycle as a retry with `term_code`=2'b10.
- R7: Bus error and acknowledge low together in the active phase give `term_code`=2'b01, never a normal completion.
- R8: With `cyc_done`=1, `data_invalid` is 1 for codes 2'b01 and 2'b10 and 0 for 2'b00. With `cyc_done`=0 it is 0.
- R9: `cyc_done` lasts exactly one clock. `term_code` reads 2'b00 whenever `cyc_done` is 0, and `cyc_busy` falls on the same edge that raises `cyc_done`.
- R10: A bus-error termination with `defer_exc`=0 at the deciding edge raises `exc_req` for one clock, together with `cyc_done`. A retry never raises `exc_req`.
- R11: A bus-error termination with `defer_exc`=1 raises no `exc_req` but sets `exc_pending`. The first edge with `exc_release`=1 while pending gives a one-clock `exc_req` after that edge and clears `exc_pending`. A deferred bus error on the same edge as a release leaves `exc_pending` set.
- R12: During a cycle, halt low without bus error, or no status at all, keeps the cycle waiting with `cyc_busy`=1 and no done strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, all state on the rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| cyc_start | input | 1 | Request to begin a bus cycle |
| ack_n | input | 1 | Transfer acknowledge, active low, already synchronous |
| berr_n | input | 1 | Bus error, active low, already synchronous |
| halt_n | input | 1 | Halt, active low, already synchronous |
| defer_exc | input | 1 | 1: hold a bus-error exception pending; 0: raise it at once |
| exc_release | input | 1 | Releases a pending exception request |
| cyc_busy | output | 1 | A bus cycle is in progress |
| cyc_done | output | 1 | One-clock strobe marking the end of a cycle |
| term_code | output | 2 | 00 normal, 01 bus error, 10 retry; valid with `cyc_done` |
| data_invalid | output | 1 | Read data of the ending cycle must be discarded |
| exc_req | output | 1 | One-clock bus-error exception request |
| exc_pending | output | 1 | A deferred exception request is waiting for release |

## Verification
Every result is registered once. The done strobe, code, invalid flag and immediate exception request appear right after the deciding edge. For an acknowledge-only cycle the deciding edge is the one after the acknowledge edge. A released exception appears right after the release edge. The bench drives each input set at a falling edge and updates its own model of the arbiter's phase at the following rising edge. It then compares every output at the next falling edge, half a period later, so each result is checked in the single cycle where it is due. Every pair of active-phase and late-window status combinations is swept under both deferral settings, together with start attempts against each non-quiet status pattern.

// File: rtl/bta_pkg.sv
package bta_pkg;
  localparam int CODE_W = 2;

  typedef enum logic [CODE_W-1:0] {
    TERM_NORMAL = 2'b00,
    TERM_BERR   = 2'b01,
    TERM_RETRY  = 2'b10
  } term_code_e;

  typedef enum logic [1:0] {
    ST_IDLE   = 2'b00,
    ST_ACTIVE = 2'b01,
    ST_LATE   = 2'b10
  } fsm_state_e;

  typedef struct packed {
    logic ack;
    logic berr;
    logic halt;
  } bus_status_t;
endpackage

// File: rtl/bta_status_decode.sv
module bta_status_decode
  import bta_pkg::*;
#(
  parameter bit ACTIVE_LOW = 1'b1
) (
  input  logic        ack_in,
  input  logic        berr_in,
  input  logic        halt_in,
  output bus_status_t stat,
  output logic        quiet
);
  generate
    if (ACTIVE_LOW) begin : g_low
      assign stat.ack  = ~ack_in;
      assign stat.berr = ~berr_in;
      assign stat.halt = ~halt_in;
    end else begin : g_high
      assign stat.ack  = ack_in;
      assign stat.berr = berr_in;
      assign stat.halt = halt_in;
    end
  endgenerate

  // Bus is quiet only when no slave drives any status line.
  assign quiet = ~(stat.ack | stat.berr | stat.halt);
endmodule

// File: rtl/bta_term_fsm.sv
module bta_term_fsm
  import bta_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_req,
  input  bus_status_t       stat,
  input  logic              quiet,
  output logic              busy,
  output logic              term_now,
  output term_code_e        code_now,
  output logic              done,
  output logic [CODE_W-1:0] code,
  output logic              data_invalid
);
  fsm_state_e state_q, state_d;

  // Decide the outcome at this edge from phase and sampled status.
  always_comb begin
    state_d  = state_q;
    term_now = 1'b0;
    code_now = TERM_NORMAL;
    unique case (state_q)
      ST_IDLE: begin
        if (start_req && quiet) state_d = ST_ACTIVE;
      end
      ST_ACTIVE: begin
        if (stat.berr && stat.halt) begin
          term_now = 1'b1;
          code_now = TERM_RETRY;
        end else if (stat.berr) begin
          term_now = 1'b1;
          code_now = TERM_BERR;
        end else if (stat.ack && !stat.halt) begin
          state_d = ST_LATE;
        end
      end
      ST_LATE: begin
        term_now = 1'b1;
        if (stat.berr && stat.halt)  code_now = TERM_RETRY;
        else if (stat.berr)          code_now = TERM_BERR;
        else                         code_now = TERM_NORMAL;
      end
      default: state_d = ST_IDLE;
    endcase
    if (term_now) state_d = ST_IDLE;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q      <= ST_IDLE;
      done         <= 1'b0;
      code         <= TERM_NORMAL;
      data_invalid <= 1'b0;
    end else begin
      state_q      <= state_d;
      done         <= term_now;
      code         <= term_now ? code_now : TERM_NORMAL;
      data_invalid <= term_now && (code_now != TERM_NORMAL);
    end
  end

  assign busy = (state_q != ST_IDLE);

  p_done_one_clk_r9: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  p_code_idle_zero_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !done |-> code == TERM_NORMAL);
  p_normal_valid_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (done && code == TERM_NORMAL) |-> !data_invalid);
  p_start_quiet_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(quiet));
  p_normal_after_window_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (done && code == TERM_NORMAL) |-> $past(state_q == ST_LATE));
  p_berr_never_normal_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && stat.berr) |=> (done && code != TERM_NORMAL));
endmodule

// File: rtl/bta_exc_ctrl.sv
module bta_exc_ctrl
  import bta_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       term_now,
  input  term_code_e code_now,
  input  logic       defer,
  input  logic       release_in,
  output logic       exc_req,
  output logic       exc_pending
);
  logic berr_term, rel_fire;

  assign berr_term = term_now && (code_now == TERM_BERR);
  assign rel_fire  = release_in && exc_pending;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      exc_req     <= 1'b0;
      exc_pending <= 1'b0;
    end else begin
      exc_req <= (berr_term && !defer) || rel_fire;
      if (berr_term && defer) exc_pending <= 1'b1;
      else if (rel_fire)      exc_pending <= 1'b0;
    end
  end

  p_exc_has_cause_r10: assert property (@(posedge clk) disable iff (!rst_n)
    exc_req |-> $past(berr_term && !defer) || $past(release_in && exc_pending));
  p_no_exc_on_retry_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (term_now && code_now == TERM_RETRY && !exc_pending) |=> !exc_req);
  p_pending_cleared_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (release_in && exc_pending && !berr_term) |=> (exc_req && !exc_pending));
endmodule

// File: rtl/bus_term_arbiter.sv
module bus_term_arbiter
  import bta_pkg::*;
#(
  parameter bit STATUS_ACTIVE_LOW = 1'b1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cyc_start,
  input  logic              ack_n,
  input  logic              berr_n,
  input  logic              halt_n,
  input  logic              defer_exc,
  input  logic              exc_release,
  output logic              cyc_busy,
  output logic              cyc_done,
  output logic [CODE_W-1:0] term_code,
  output logic              data_invalid,
  output logic              exc_req,
  output logic              exc_pending
);
  bus_status_t stat;
  logic        quiet;
  logic        term_now;
  term_code_e  code_now;

  bta_status_decode #(.ACTIVE_LOW(STATUS_ACTIVE_LOW)) u_decode (
    .ack_in (ack_n),
    .berr_in(berr_n),
    .halt_in(halt_n),
    .stat   (stat),
    .quiet  (quiet)
  );

  bta_term_fsm u_fsm (
    .clk         (clk),
    .rst_n       (rst_n),
    .start_req   (cyc_start),
    .stat        (stat),
    .quiet       (quiet),
    .busy        (cyc_busy),
    .term_now    (term_now),
    .code_now    (code_now),
    .done        (cyc_done),
    .code        (term_code),
    .data_invalid(data_invalid)
  );

  bta_exc_ctrl u_exc (
    .clk        (clk),
    .rst_n      (rst_n),
    .term_now   (term_now),
    .code_now   (code_now),
    .defer      (defer_exc),
    .release_in (exc_release),
    .exc_req    (exc_req),
    .exc_pending(exc_pending)
  );

  p_busy_drops_with_done_r9: assert property (@(posedge clk) disable iff (!rst_n)
    cyc_done |-> !cyc_busy);
  p_immediate_exc_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (cyc_done && term_code == TERM_BERR && !$past(defer_exc)) |-> exc_req);
endmodule

// File: tb/bus_term_arbiter_tb_top.sv
module bus_term_arbiter_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cyc_start = 1'b0, ack_n = 1'b1, berr_n = 1'b1, halt_n = 1'b1;
  logic defer_exc = 1'b0, exc_release = 1'b0;
  logic cyc_busy, cyc_done, data_invalid, exc_req, exc_pending;
  logic [1:0] term_code;

  int n_checks = 0;
  int n_fail = 0;
  bit finished = 0;

  // model state: 0 idle, 1 active, 2 late window
  int   m_st = 0;
  logic m_pend = 1'b0;

  always #10 clk = ~clk;  // 50 MHz

  bus_term_arbiter dut_i (
    .clk(clk), .rst_n(rst_n), .cyc_start(cyc_start),
    .ack_n(ack_n), .berr_n(berr_n), .halt_n(halt_n),
    .defer_exc(defer_exc), .exc_release(exc_release),
    .cyc_busy(cyc_busy), .cyc_done(cyc_done), .term_code(term_code),
    .data_invalid(data_invalid), .exc_req(exc_req), .exc_pending(exc_pending)
  );

  task automatic check(input string req, input logic done_e, input logic [1:0] code_e,
                       input logic inv_e, input logic exc_e, input logic busy_e,
                       input logic pend_e);
    logic [5:0] act, exp_v;
    act   = {cyc_done, term_code, data_invalid, exc_req, cyc_busy};
    exp_v = {done_e, code_e, inv_e, exc_e, busy_e};
    n_checks++;
    if (act !== exp_v || exc_pending !== pend_e) begin
      n_fail++;
      $display("FAIL %s: done/code/inv/exc/busy actual %b pend %b, expected %b pend %b",
               req, act, exc_pending, exp_v, pend_e);
    end
  endtask

  // Drive one cycle of inputs (actives given high), advance model, compare.
  task automatic step(input logic st, input logic a, input logic b, input logic h,
                      input logic dfr, input logic rel);
    logic e_done, e_inv, e_exc, term, rel_fire;
    logic [1:0] e_code;
    string tag;
    cyc_start = st; ack_n = ~a; berr_n = ~b; halt_n = ~h;
    defer_exc = dfr; exc_release = rel;
    e_done = 0; e_code = 2'b00; e_inv = 0; e_exc = 0; term = 0;
    tag = "R12";
    case (m_st)
      0: begin
        tag = "R2";
        if (st && !a && !b && !h) m_st = 1;
      end
      1: begin
        if (b && h)      begin term = 1; e_code = 2'b10; tag = "R6"; end
        else if (b)      begin term = 1; e_code = 2'b01; tag = a ? "R7" : "R3"; end
        else if (a && !h) begin m_st = 2; tag = "R4"; end
      end
      default: begin
        term = 1;
        if (b && h)  begin e_code = 2'b10; tag = "R6"; end
        else if (b)  begin e_code = 2'b01; tag = "R5"; end
        else         begin e_code = 2'b00; tag = "R4"; end
      end
    endcase
    rel_fire = rel && m_pend;
    if (rel_fire) begin m_pend = 0; e_exc = 1; tag = {tag, "/R11"}; end
    if (term) begin
      e_done = 1; e_inv = (e_code != 2'b00); m_st = 0;
      tag = {tag, "/R8/R9"};
      if (e_code == 2'b01) begin
        if (dfr) begin m_pend = 1; tag = {tag, "/R11"}; end
        else     begin e_exc = 1;  tag = {tag, "/R10"}; end
      end
    end
    @(posedge clk);
    @(negedge clk);
    check(tag, e_done, e_code, e_inv, e_exc, m_st != 0, m_pend);
  endtask

  initial begin
    #2000000;
    if (!finished) begin
      n_checks++; n_fail++;
      $display("FAIL watchdog: actual hung, expected completion");
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R1", 0, 2'b00, 0, 0, 0, 0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1", 0, 2'b00, 0, 0, 0, 0);

    // R2: start ignored under each non-quiet status pattern
    for (int c = 1; c < 8; c++) step(1, c[2], c[1], c[0], 0, 0);

    // Full sweep: active-phase status x late/next status x deferral
    for (int c1 = 0; c1 < 8; c1++) begin
      for (int c2 = 0; c2 < 8; c2++) begin
        for (int d = 0; d < 2; d++) begin
          step(1, 0, 0, 0, d[0], 0);
          step(0, c1[2], c1[1], c1[0], d[0], 0);
          step(0, c2[2], c2[1], c2[0], d[0], 0);
          for (int k = 0; k < 4 && m_st != 0; k++) begin
            if (m_st == 1) step(0, 1, 0, 0, d[0], 0);
            else           step(0, 0, 0, 0, d[0], 0);
          end
          step(0, 0, 0, 0, 0, 1);  // release any pending request (R11)
          step(0, 0, 0, 0, 0, 0);
        end
      end
    end

    // R11: deferred bus error on the same edge as a release keeps pending
    step(1, 0, 0, 0, 1, 0);
    step(0, 0, 1, 0, 1, 0);
    step(1, 0, 0, 0, 1, 0);
    step(0, 0, 1, 0, 1, 1);
    step(0, 0, 0, 0, 0, 1);
    step(0, 0, 0, 0, 0, 0);

    finished = 1;
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end
endmodule